// File: doc/BRIEF.md
# Byte-Lane I/O Port Slave

This block hangs off a 16-bit processor bus and gives the processor one output port and one input port in the I/O address space. A cycle is taken only when the memory/IO select line is low. The whole 16-bit port address must then match one of two fixed port numbers. Bus bit 0 and an active-low high-byte enable split every access into an even lane (data bits 7:0) and an odd lane (data bits 15:8). Each lane is decoded on its own, so one decoder handles byte and word cycles alike.

A write strobe at the output port loads the selected lanes of a 16-bit register, and that register drives two 8-bit indicator groups. A read strobe at the input port places the switch inputs on the selected lanes. Each lane has a drive enable, which stands in for a tri-state buffer. Any lane that is not driven reads as zero with its enable low.

Top module: `io_lane_port`

## Requirements
- R1: When `mem_sel` is 1 (memory cycle), no lane is written and no read enable is raised, whatever the address and strobes.
- R2: All 16 address bits take part in decode. The output port answers only at addresses 0x0004 (even lane) and 0x0005 (odd lane). The input port answers only at 0x0006 and 0x0007. No other address has any effect.
- R3: With `addr[0]`=0 and `bhe_n`=1, only the even lane (data bits 7:0) is used.
- R4: With `addr[0]`=1 and `bhe_n`=0, only the odd lane (data bits 15:8) is used.
- R5: With `addr[0]`=0 and `bhe_n`=0, both lanes transfer as one 16-bit word. With `addr[0]`=1 and `bhe_n`=1, no lane is used.
- R6: A clock edge with `iow_n`=0 and a matching output-port decode loads `wdata` lanes into `led_out`, visible right after that edge.
- R7: With `ior_n`=0 and a matching input-port decode, `rdata` carries `sw_in[7:0]` on bits 7:0 and `sw_in[15:8]` on bits 15:8 for the enabled lanes, combinationally. `rd_oe[0]` enables the even lane and `rd_oe[1]` the odd lane.
- R8: A byte write leaves the other lane of `led_out` unchanged.
- R9: A read enable is low unless both the read strobe and the input-port decode are active. A lane whose enable is low reads 0 on `rdata`.
- R10: Synchronous active-high `rst` clears `led_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_sel | input | 1 | 1 = memory cycle (ignored), 0 = I/O cycle |
| addr | input | 16 | Port address, bit 0 selects the even lane when low |
| bhe_n | input | 1 | Active-low high-byte enable (odd lane) |
| iow_n | input | 1 | Active-low I/O write strobe |
| ior_n | input | 1 | Active-low I/O read strobe |
| wdata | input | 16 | Write data from the processor |
| sw_in | input | 16 | Switch levels, bits 7:0 even lane, 15:8 odd lane |
| rdata | output | 16 | Read data lanes, zero where not driven |
| rd_oe | output | 2 | Read drive enable for each lane (bit 0 even, bit 1 odd) |
| led_out | output | 16 | Output register driving the indicators |

## Verification
The read path has no registers, so `rd_oe` and `rdata` are valid in the same cycle that the address and strobe are applied. The write path has one register, so `led_out` shows a write right after the rising edge at which `iow_n` is low. The bench changes inputs on the falling edge and samples 5 ns after the next rising edge. At that point the read outputs still reflect the applied vector and the write has just landed, so one sample point covers both paths. Ignored cycles are shown to have no effect by reading `led_out` after the vector, before the next vector can change it.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = BYTE_W * LANES;

  // Lane request from the low address bit and the active-low high enable.
  // Bit 0 = even lane, bit 1 = odd lane.
  function automatic logic [LANES-1:0] lane_pick(input logic a0, input logic bhe_n);
    return {~bhe_n, ~a0};
  endfunction

  // Port match: every bit above bit 0 must agree; bit 0 is the lane selector.
  function automatic logic port_match(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] port);
    return a[ADDR_W-1:1] == port[ADDR_W-1:1];
  endfunction
endpackage

// File: rtl/io_lane_decode.sv
module io_lane_decode
  import io_port_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OUT_PORT = 16'h0004,
  parameter logic [ADDR_W-1:0] IN_PORT  = 16'h0006
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bhe_n,
  input  logic              iow_n,
  input  logic              ior_n,
  output logic [LANES-1:0]  wr_lane,
  output logic [LANES-1:0]  rd_lane
);
  logic             io_cycle;
  logic             out_hit;
  logic             in_hit;
  logic [LANES-1:0] lanes;

  assign io_cycle = ~mem_sel;
  assign lanes    = lane_pick(addr[0], bhe_n);
  assign out_hit  = io_cycle && port_match(addr, OUT_PORT);
  assign in_hit   = io_cycle && port_match(addr, IN_PORT);

  always_comb begin
    wr_lane = '0;
    rd_lane = '0;
    if (out_hit && !iow_n) wr_lane = lanes;
    if (in_hit && !ior_n)  rd_lane = lanes;
  end

  // R1
  mem_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mem_sel |-> (wr_lane == '0 && rd_lane == '0));
  // R2
  wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lane != '0) |-> (addr[ADDR_W-1:1] == OUT_PORT[ADDR_W-1:1]));
  // R3
  even_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lane[0] || rd_lane[0]) |-> !addr[0]);
  // R4
  odd_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_lane[1] || rd_lane[1]) |-> !bhe_n);
endmodule

// File: rtl/io_out_latch.sv
module io_out_latch
  import io_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)             q[i*BYTE_W +: BYTE_W] <= '0;
      else if (wr_lane[i]) q[i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
    end

    // R8
    hold_lane_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_lane[i] |=> $stable(q[i*BYTE_W +: BYTE_W]));
    // R6
    load_lane_chk: assert property (@(posedge clk) disable iff (rst)
      wr_lane[i] |=> q[i*BYTE_W +: BYTE_W] == $past(wdata[i*BYTE_W +: BYTE_W]));
  end
endmodule

// File: rtl/io_in_drive.sv
module io_in_drive
  import io_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  rd_lane,
  input  logic [DATA_W-1:0] sw,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  oe
);
  assign oe = rd_lane;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rdata[i*BYTE_W +: BYTE_W] = oe[i] ? sw[i*BYTE_W +: BYTE_W] : '0;

    // R7
    drive_lane_chk: assert property (@(posedge clk) disable iff (rst)
      oe[i] |-> rdata[i*BYTE_W +: BYTE_W] == sw[i*BYTE_W +: BYTE_W]);
    // R9
    idle_lane_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_lane[i] |-> (!oe[i] && rdata[i*BYTE_W +: BYTE_W] == '0));
  end
endmodule

// File: rtl/io_lane_port.sv
module io_lane_port
  import io_port_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OUT_PORT = 16'h0004,
  parameter logic [ADDR_W-1:0] IN_PORT  = 16'h0006
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bhe_n,
  input  logic              iow_n,
  input  logic              ior_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sw_in,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  rd_oe,
  output logic [DATA_W-1:0] led_out
);
  logic [LANES-1:0] wr_lane;
  logic [LANES-1:0] rd_lane;

  io_lane_decode #(.OUT_PORT(OUT_PORT), .IN_PORT(IN_PORT)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .mem_sel (mem_sel),
    .addr    (addr),
    .bhe_n   (bhe_n),
    .iow_n   (iow_n),
    .ior_n   (ior_n),
    .wr_lane (wr_lane),
    .rd_lane (rd_lane)
  );

  io_out_latch u_out (
    .clk     (clk),
    .rst     (rst),
    .wr_lane (wr_lane),
    .wdata   (wdata),
    .q       (led_out)
  );

  io_in_drive u_in (
    .clk     (clk),
    .rst     (rst),
    .rd_lane (rd_lane),
    .sw      (sw_in),
    .rdata   (rdata),
    .oe      (rd_oe)
  );

  // R5
  word_both_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_sel && !ior_n && !addr[0] && !bhe_n && addr[ADDR_W-1:1] == IN_PORT[ADDR_W-1:1])
      |-> $countones(rd_oe) == 2);
endmodule

// File: tb/tb_io_lane_port.sv
module tb_io_lane_port;
  typedef struct packed {
    logic [3:0]  req;
    logic        mem;
    logic [15:0] a;
    logic        bhe_n;
    logic        wr;
    logic        rd;
    logic [15:0] wd;
    logic [15:0] e_led;
    logic [1:0]  e_oe;
    logic [15:0] e_rd;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'd5,  1'b0, 16'h0004, 1'b0, 1'b1, 1'b0, 16'h1234, 16'h1234, 2'b00, 16'h0000}, // R5 word write
    '{4'd3,  1'b0, 16'h0004, 1'b1, 1'b1, 1'b0, 16'hABCD, 16'h12CD, 2'b00, 16'h0000}, // R3 even byte
    '{4'd4,  1'b0, 16'h0005, 1'b0, 1'b1, 1'b0, 16'h9911, 16'h99CD, 2'b00, 16'h0000}, // R4 odd byte
    '{4'd1,  1'b1, 16'h0004, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h99CD, 2'b00, 16'h0000}, // R1 memory write
    '{4'd2,  1'b0, 16'h0104, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h99CD, 2'b00, 16'h0000}, // R2 alias
    '{4'd2,  1'b0, 16'h8004, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h99CD, 2'b00, 16'h0000}, // R2 top bit
    '{4'd7,  1'b0, 16'h0006, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h99CD, 2'b11, 16'h3CA5}, // R7 word read
    '{4'd3,  1'b0, 16'h0006, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h99CD, 2'b01, 16'h00A5}, // R3 even read
    '{4'd4,  1'b0, 16'h0007, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h99CD, 2'b10, 16'h3C00}, // R4 odd read
    '{4'd1,  1'b1, 16'h0006, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h99CD, 2'b00, 16'h0000}, // R1 memory read
    '{4'd2,  1'b0, 16'h0106, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h99CD, 2'b00, 16'h0000}, // R2 read alias
    '{4'd9,  1'b0, 16'h0006, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h99CD, 2'b00, 16'h0000}, // R9 no strobe
    '{4'd5,  1'b0, 16'h0005, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h99CD, 2'b00, 16'h0000}, // R5 no lane
    '{4'd9,  1'b0, 16'h0004, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h99CD, 2'b00, 16'h0000}, // R9 read at out port
    '{4'd8,  1'b0, 16'h0006, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h99CD, 2'b00, 16'h0000}, // R8 write at in port
    '{4'd6,  1'b0, 16'h0004, 1'b0, 1'b1, 1'b0, 16'h5A5A, 16'h5A5A, 2'b00, 16'h0000}  // R6 word write
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_sel = 1'b0;
  logic [15:0] addr = '0;
  logic        bhe_n = 1'b1;
  logic        iow_n = 1'b1;
  logic        ior_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] sw_in = 16'h3CA5;
  logic [15:0] rdata;
  logic [1:0]  rd_oe;
  logic [15:0] led_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  io_lane_port dut (
    .clk(clk), .rst(rst), .mem_sel(mem_sel), .addr(addr), .bhe_n(bhe_n),
    .iow_n(iow_n), .ior_n(ior_n), .wdata(wdata), .sw_in(sw_in),
    .rdata(rdata), .rd_oe(rd_oe), .led_out(led_out)
  );

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    mem_sel = v.mem; addr = v.a; bhe_n = v.bhe_n;
    iow_n = ~v.wr; ior_n = ~v.rd; wdata = v.wd;
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    @(negedge clk);
    iow_n = 1'b1; ior_n = 1'b1; mem_sel = 1'b0; addr = '0; bhe_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R10: reset state
    chk(10, "led after reset", led_out, 16'h0000);
    chk(9,  "oe after reset", {14'd0, rd_oe}, 16'h0000);
    chk(9,  "rdata after reset", rdata, 16'h0000);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk(VEC[i].req, $sformatf("vec %0d led", i), led_out, VEC[i].e_led);
      chk(VEC[i].req, $sformatf("vec %0d oe", i), {14'd0, rd_oe}, {14'd0, VEC[i].e_oe});
      chk(VEC[i].req, $sformatf("vec %0d rdata", i), rdata, VEC[i].e_rd);
    end

    // R7: switches followed combinationally while read is held
    @(negedge clk);
    mem_sel = 1'b0; addr = 16'h0006; bhe_n = 1'b0; iow_n = 1'b1; ior_n = 1'b0;
    #2 sw_in = 16'hF00D;
    #2 chk(7, "read follows switches", rdata, 16'hF00D);
    idle();
    #2 chk(9, "released after read", {14'd0, rd_oe}, 16'h0000);

    // R8: odd-lane write keeps even lane
    apply('{4'd8, 1'b0, 16'h0005, 1'b0, 1'b1, 1'b0, 16'h77EE, 16'h0000, 2'b00, 16'h0000});
    chk(8, "odd write keeps even", led_out, 16'h775A);
    idle();

    // R10: reset in mid-run clears register
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #5;
    chk(10, "reset clears led", led_out, 16'h0000);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #5;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule